// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a synthesizable I2C slave that behaves like a 256-byte serial EEPROM. It samples the open-drain clock and data lines on the system clock through a two-flop synchronizer. It drives the data line only by asserting an enable that pulls the line low. The slave answers a 7-bit device address. The upper four bits of that address are fixed at binary 1010 and the lower three bits come from strap inputs. The storage is an internal register array, cleared by reset.

A master writes by sending the device address with direction 0 and then a word address, which loads the internal pointer. Each further byte is stored at the pointer. The pointer then advances within its 8-byte page, so a long burst folds back and overwrites the start of the page. A master reads by sending the device address with direction 1. The slave returns bytes from the pointer and advances across the full 256-byte space after each one. A write of only the word address, followed by a repeated start and a read address, gives a random read. A write-protect input keeps the array unchanged while the bus traffic is still acknowledged.

Top module: `i2c_ee_slave`

## Requirements
- R1: A start (data falls while the clock is high) restarts address reception from any state, including in the middle of a byte. A stop (data rises while the clock is high) returns the slave to idle and releases the data line. A partly received byte is discarded and changes neither the memory nor the pointer.
- R2: The first byte after a start carries the device address in bits 7..1 and the direction in bit 0. The slave pulls data low in the ninth clock only when bits 7..4 equal 1010 and bits 3..1 equal the straps A2..A0. Otherwise it leaves the line released and ignores the bus until the next start or stop.
- R3: Bytes are 8 bits, MSB first, each followed by a ninth acknowledge clock. The slave changes its data drive only while the clock is low, except when it releases on a start or stop. It never drives the line high.
- R4: In a write transfer, the byte after the device address loads the word pointer and is acknowledged. Each later byte is stored at the pointer and acknowledged.
- R5: After each stored byte, pointer bits 2..0 increment modulo 8 and bits 7..3 stay unchanged. A burst longer than the 8-byte page overwrites earlier bytes of that page.
- R6: While write-protect is high, the device address, the word address and the data bytes are all acknowledged, the pointer advances as in R5, and the memory contents do not change.
- R7: In a read transfer, the slave sends the byte at the pointer, then increments the pointer by one over the whole space, wrapping from 0xFF to 0x00.
- R8: When the master does not acknowledge a read byte, the slave releases the line and drives nothing on further clocks until a stop or start. The pointer is left at the next location.
- R9: A write of only the word address, followed by a repeated start with a read address, returns data starting at that word address.
- R10: After reset the data line is released, the pointer is 0x00 and every memory byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low; low releases it |
| strap_i | input | 3 | Strap bits A2..A0 that form the low device-address bits |
| wp_i | input | 1 | Write protect; high leaves memory unchanged |

## Verification
The hardest cases to reach from the ports are the pointer folding inside a page during a write and the pointer crossing from 0xFF to 0x00 during a read. Both only appear after the bus has carried the right word address and enough bytes. The bench fills the whole array with a computed pattern, one page per transfer, and reads it back in a single 256-byte burst that crosses the top of the space. A burst of 11 bytes started mid-page shows the fold-back. Stops and repeated starts placed in the middle of a byte, and clocks sent after a master NACK, check that partial bytes are discarded and that the slave stays silent.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  // R1: bus conditions and clock edges never coincide
  a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R4: a granted write lands at its address
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave #(
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  parameter int         MEM_AW      = 8,
  parameter int         PAGE_AW     = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import i2c_ee_pkg::*;

  localparam int BYTE_W = 8;

  function automatic logic [MEM_AW-1:0] page_next(input logic [MEM_AW-1:0] p);
    logic [PAGE_AW-1:0] low;
    low = p[PAGE_AW-1:0] + 1'b1;
    return {p[MEM_AW-1:PAGE_AW], low};
  endfunction

  function automatic logic [MEM_AW-1:0] seq_next(input logic [MEM_AW-1:0] p);
    return p + 1'b1;
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ee_state_e          state;
  logic [3:0]         bitcnt;
  logic [BYTE_W-1:0]  shreg;
  logic [MEM_AW-1:0]  ptr;
  logic               sda_oe, rw_q, in_ack;
  logic [BYTE_W-1:0]  rd_byte;

  // named internal events
  logic rx_state, byte_done, ack_end, dev_hit, data_evt, mem_we, rd_load_evt;
  assign rx_state    = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WDATA);
  assign byte_done   = rx_state && scl_fall && !in_ack && (bitcnt == 4'd8);
  assign ack_end     = rx_state && scl_fall && in_ack;
  assign dev_hit     = (shreg[7:1] == {DEV_PREFIX, strap_i});
  assign data_evt    = byte_done && (state == ST_WDATA);
  assign mem_we      = data_evt && !wp_i;
  assign rd_load_evt = (ack_end && (state == ST_DEV) && rw_q) ||
                       ((state == ST_RACK) && scl_fall && in_ack);

  i2c_ee_store #(.AW(MEM_AW), .DW(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      rw_q   <= 1'b0;
      in_ack <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise && !in_ack && bitcnt < 4'd8) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (state == ST_DEV) begin
              if (dev_hit) begin
                rw_q   <= shreg[0];
                in_ack <= 1'b1;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_HOLD;
              end
            end else begin
              if (state == ST_WORD) ptr <= shreg[MEM_AW-1:0];
              else                  ptr <= page_next(ptr);
              in_ack <= 1'b1;
              sda_oe <= 1'b1;
            end
          end else if (ack_end) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (state == ST_DEV && rw_q) begin
              state  <= ST_RDATA;
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
              ptr    <= seq_next(ptr);
            end else begin
              sda_oe <= 1'b0;
              state  <= (state == ST_DEV) ? ST_WORD : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              in_ack <= 1'b0;
              state  <= ST_RACK;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_s) state  <= ST_HOLD;
            else       in_ack <= 1'b1;
          end else if (rd_load_evt) begin
            shreg  <= rd_byte;
            sda_oe <= ~rd_byte[BYTE_W-1];
            ptr    <= seq_next(ptr);
            bitcnt <= '0;
            in_ack <= 1'b0;
            state  <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe;

  // R1: a stop leaves the slave idle with the line released
  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_oe);

  // R2: an unaddressed or finished slave never drives
  a_r2_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !sda_oe);

  // R3: drive changes only with the clock low, outside bus conditions
  a_r3_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  // R5: a stored byte moves the pointer within its page
  a_r5_page_fold: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt |=> (ptr[MEM_AW-1:PAGE_AW] == $past(ptr[MEM_AW-1:PAGE_AW])) &&
                 (ptr[PAGE_AW-1:0] == $past(ptr[PAGE_AW-1:0]) + 1'b1));

  // R7: each byte loaded for reading advances the pointer over the full space
  a_r7_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load_evt |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: tb/tb_i2c_ee_slave.sv
module tb_i2c_ee_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0;
  logic dut_oe;
  wire  sda_line = ~(m_sda_low | dut_oe);

  int nvec = 0;
  int nbad = 0;
  logic [7:0] mdl [256];
  logic [7:0] mptr;

  always #4 clk = ~clk;

  i2c_ee_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(dut_oe), .strap_i(strap), .wp_i(wp)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clock_bit(input logic drive_low, output logic s);
    tick(3); m_sda_low = drive_low;
    tick(3); m_scl = 1'b1;
    tick(3); s = sda_line;
    tick(3); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    m_scl = 1'b0;
    tick(3); m_sda_low = 1'b0;
    tick(3); m_scl = 1'b1;
    tick(3); m_sda_low = 1'b1;
    tick(3); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_scl = 1'b0;
    tick(3); m_sda_low = 1'b1;
    tick(3); m_scl = 1'b1;
    tick(3); m_sda_low = 1'b0;
    tick(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
    clock_bit(1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b0, s);
      b[i] = s;
    end
    clock_bit(give_ack, s);
  endtask

  function automatic logic [7:0] dev_w();
    return {4'b1010, strap, 1'b0};
  endfunction

  function automatic logic [7:0] dev_r();
    return {4'b1010, strap, 1'b1};
  endfunction

  function automatic logic [7:0] pg_next(input logic [7:0] p);
    return (p & 8'hF8) | ((p + 8'd1) % 8'd8);
  endfunction

  // R4 R5 R6: page write with the model following the protocol rules
  task automatic write_block(input logic [7:0] wa, input int n, input logic [7:0] seed, input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(dev_w(), a); chk(a, 1, req);
    send_byte(wa, a);      chk(a, 1, req);
    mptr = wa;
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 13);
      send_byte(d, a); chk(a, 1, req);
      if (!wp) mdl[mptr] = d;
      mptr = pg_next(mptr);
    end
    bus_stop();
  endtask

  // R7 R9: random (word address + repeated start) or current-address read
  task automatic read_seq(input logic rnd, input logic [7:0] wa, input int n,
                          input logic extra, input string req);
    logic a;
    logic [7:0] b;
    bus_start();
    if (rnd) begin
      send_byte(dev_w(), a); chk(a, 1, req);
      send_byte(wa, a);      chk(a, 1, req);
      mptr = wa;
      bus_start();
    end
    send_byte(dev_r(), a); chk(a, 1, req);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b, mdl[mptr], req);
      mptr = mptr + 8'd1;
    end
    if (extra) begin
      recv_byte(1'b0, b);
      chk(b, 8'hFF, "R8 silent after master NACK");
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic a, s;
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mptr = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk(dut_oe, 0, "R10 line released after reset");

    // R10: memory cleared, pointer at zero
    read_seq(1'b0, 8'h00, 2, 1'b0, "R10 cleared memory from pointer 0");

    // R2: address sweep over every strap and low-address pair
    for (int st = 0; st < 8; st++) begin
      for (int lo = 0; lo < 8; lo++) begin
        strap = 3'(st);
        bus_start();
        send_byte({4'b1010, 3'(lo), 1'b0}, a);
        chk(a, (st == lo), "R2 address match");
        bus_stop();
      end
    end
    strap = 3'b101;
    foreach (mdl[k]) ;
    for (int p = 0; p < 16; p++) begin
      if (p != 10) begin
        bus_start();
        send_byte({4'(p), strap, 1'b1}, a);
        chk(a, 0, "R2 wrong prefix not acknowledged");
        bus_stop();
      end
    end

    // R4: fill the whole array one page per transfer
    for (int pg = 0; pg < 32; pg++)
      write_block(8'(pg * 8), 8, 8'(pg * 5 + 1), "R4 page fill");
    // R7: one burst over the full space ending at the top and wrapping
    read_seq(1'b1, 8'h00, 256, 1'b0, "R7 full sequential read");
    read_seq(1'b0, 8'h00, 1, 1'b0, "R7 pointer wrapped to 0x00");

    // R5: burst of 11 starting mid-page folds back
    write_block(8'h13, 11, 8'hA0, "R5 page fold write");
    read_seq(1'b1, 8'h10, 8, 1'b0, "R5 page fold contents");
    read_seq(1'b1, 8'h18, 1, 1'b0, "R5 next page untouched");

    // R6: protected writes acknowledged but not stored
    wp = 1'b1;
    write_block(8'h40, 5, 8'h5C, "R6 protected write acks");
    wp = 1'b0;
    read_seq(1'b1, 8'h40, 5, 1'b0, "R6 protected contents unchanged");

    // R7: read across 0xFF into 0x00
    read_seq(1'b1, 8'hFE, 4, 1'b0, "R7 read across top");

    // R8: master NACK then more clocks; slave stays off the line
    read_seq(1'b1, 8'h20, 2, 1'b1, "R8 read before NACK");
    read_seq(1'b0, 8'h00, 1, 1'b0, "R8 pointer after NACK");

    // R1: stop in the middle of a data byte discards it
    bus_start();
    send_byte(dev_w(), a); chk(a, 1, "R1 addr");
    send_byte(8'h30, a);   chk(a, 1, "R1 word");
    mptr = 8'h30;
    for (int i = 0; i < 3; i++) clock_bit(1'b0, s);
    bus_stop();
    read_seq(1'b0, 8'h00, 1, 1'b0, "R1 partial byte dropped at stop");

    // R1 R9: repeated start in the middle of a byte, then read
    bus_start();
    send_byte(dev_w(), a); chk(a, 1, "R9 addr");
    send_byte(8'h31, a);   chk(a, 1, "R9 word");
    mptr = 8'h31;
    for (int i = 0; i < 5; i++) clock_bit(1'b1, s);
    read_seq(1'b0, 8'h00, 2, 1'b0, "R9 read after mid-byte repeated start");
    read_seq(1'b1, 8'h31, 1, 1'b0, "R1 location kept after aborted byte");

    tick(4);
    chk(dut_oe, 0, "R3 line released at end");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule